// File: doc/BRIEF.md
# Host-to-Service-Processor Doorbell Mailbox

This block is a small register window through which a host processor hands commands to a service processor. The host sees a 256-byte window on a simple 32-bit register bus. Writing the command word at offset 0x00 rings a doorbell toward the service processor and marks the mailbox busy. The host can load up to 16 bytes of arguments into a write buffer beforehand, poll a packed status word at offset 0x04, and collect up to 16 bytes of results from a read buffer once the command finishes.

The service processor side receives a one-cycle doorbell pulse and the latched command word. It reads the argument words by index, writes result words by index, and finishes the command with a done strobe that carries an error flag and an 8-bit error code. If the accepted command asked for it, completion also sends a one-cycle interrupt pulse to the host, and that pulse needs no clearing. While a command is outstanding, further command writes from the host are dropped. All contents, fields and sizes are parameters; the defaults give 16-byte buffers at 0x80 and 0x90.

Top module: `hostmbox_top`

## Requirements
- R1: A host write to offset 0x00 while the mailbox is idle is accepted. On the clock edge of the write, the full 32-bit word appears on `r_cmd_word`, `r_doorbell` is high for exactly the following cycle, and busy becomes 1.
- R2: A host write to offset 0x00 while busy is 1 is ignored. It raises no doorbell and changes neither `r_cmd_word` nor the status command id.
- R3: The host read at offset 0x04 returns the status word: bit 0 busy, bit 1 error, bits [3:2] zero, bits [7:4] the id (command bits [15:12]) of the last accepted command, bits [15:8] the parameter `INIT_ID`, bits [23:16] the error code, and bits [31:24] zero. An accepted command clears error and error code.
- R4: `r_done` while busy clears busy on that edge and loads error from `r_err` and the error code from `r_err_code`. `r_done` while idle changes nothing and raises no interrupt.
- R5: When the accepted command had bit 8 set, the completing `r_done` gives `h_irq` high for exactly one cycle, in the cycle after the done edge. With bit 8 clear, `h_irq` stays low.
- R6: A host write to byte offset 0x80+4*i stores word i of the write buffer. The service processor reads it with `r_wbuf_idx`=i, and the data appears on `r_wbuf_data` one cycle later.
- R7: A service-processor write with `r_rbuf_we`, `r_rbuf_idx`=i stores word i of the read buffer. A host read at byte offset 0x90+4*i returns it.
- R8: Read data is on `h_rdata` in the cycle after `h_rd_en`. Reads of offset 0x00, of the write buffer and of unmapped offsets return zero.
- R9: Host writes to offset 0x04, to the read buffer and to unmapped offsets change no state.
- R10: If `r_done` and a host command write fall in the same cycle while busy, the done is taken and the command is dropped (no doorbell, `r_cmd_word` kept). A command written after that is accepted.
- R11: After reset, busy, error, error code and command id are zero, and `r_doorbell` and `h_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address within the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after `h_rd_en` |
| h_irq | output | 1 | One-cycle completion interrupt to the host |
| r_doorbell | output | 1 | One-cycle doorbell pulse to the service processor |
| r_cmd_word | output | 32 | Latched command word |
| r_wbuf_idx | input | IDX_W | Write-buffer word index to read |
| r_wbuf_data | output | 32 | Write-buffer word, one cycle after the index |
| r_rbuf_we | input | 1 | Read-buffer write enable |
| r_rbuf_idx | input | IDX_W | Read-buffer word index to write |
| r_rbuf_wdata | input | 32 | Read-buffer write data |
| r_done | input | 1 | Completion strobe |
| r_err | input | 1 | Error flag captured with `r_done` |
| r_err_code | input | 8 | Error code captured with `r_done` |

## Verification
The completion strobe from the service processor and a new command write from the host can arrive in the same cycle. The bench makes this happen by starting a command with the interrupt bit set, then driving `r_done` and a command write in the same half-cycle. It then checks that the interrupt fires, that no doorbell appears, that the latched word and status id still belong to the old command, and that the next command write is accepted. Every other command in the sweep is also followed by a write attempt while busy, so the busy gate is checked with all 16 ids and both interrupt settings.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

  // byte offsets inside the host window
  localparam logic [31:0] CMD_OFF  = 32'h0000_0000;
  localparam logic [31:0] STAT_OFF = 32'h0000_0004;
  localparam logic [31:0] WBUF_OFF = 32'h0000_0080;

  // command word fields
  localparam int CMD_IOC_BIT = 8;
  localparam int CMD_ID_LSB  = 12;
  localparam int CMD_ID_W    = 4;

  typedef struct packed {
    logic [7:0]          rsvd_hi;
    logic [7:0]          err_code;
    logic [7:0]          init_id;
    logic [CMD_ID_W-1:0] cmd_id;
    logic [1:0]          rsvd_lo;
    logic                err;
    logic                busy;
  } status_t;

  typedef enum logic [1:0] {
    RSEL_ZERO   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_RBUF   = 2'd2
  } rsel_e;

endpackage

// File: rtl/hmb_decode.sv
module hmb_decode #(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 16,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              cmd_wr,
  output logic              wbuf_wr,
  output logic              stat_rd,
  output logic              rbuf_rd,
  output logic [IDX_W-1:0]  idx
);
  import hmb_pkg::*;

  localparam logic [31:0] WB_END = WBUF_OFF + 32'(BUF_BYTES);
  localparam logic [31:0] RB_END = WB_END + 32'(BUF_BYTES);

  logic [31:0] a32;
  logic        hit_cmd, hit_stat, hit_wbuf, hit_rbuf;

  always_comb begin
    a32      = 32'(addr);
    hit_cmd  = (a32[31:2] == CMD_OFF[31:2]);
    hit_stat = (a32[31:2] == STAT_OFF[31:2]);
    hit_wbuf = (a32 >= WBUF_OFF) && (a32 < WB_END);
    hit_rbuf = (a32 >= WB_END) && (a32 < RB_END);
    // buffers are aligned to their size, so low word bits are the index
    idx      = a32[IDX_W+1:2];
    cmd_wr   = wr && hit_cmd;
    wbuf_wr  = wr && hit_wbuf;
    stat_rd  = rd && hit_stat;
    rbuf_rd  = rd && hit_rbuf;
  end

endmodule

// File: rtl/hmb_sdp_ram.sv
module hmb_sdp_ram #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hmb_ctrl.sv
module hmb_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] wdata,
  input  logic        done,
  input  logic        done_err,
  input  logic [7:0]  done_code,
  output logic        busy,
  output logic        err,
  output logic [7:0]  err_code,
  output logic [hmb_pkg::CMD_ID_W-1:0] cmd_id,
  output logic [31:0] cmd_word,
  output logic        doorbell,
  output logic        irq
);
  import hmb_pkg::*;

  logic ioc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      cmd_id   <= '0;
      cmd_word <= '0;
      ioc_q    <= 1'b0;
      doorbell <= 1'b0;
      irq      <= 1'b0;
    end else begin
      doorbell <= 1'b0;
      irq      <= 1'b0;
      if (busy) begin
        // completion has priority; command writes are dropped while busy
        if (done) begin
          busy     <= 1'b0;
          err      <= done_err;
          err_code <= done_code;
          irq      <= ioc_q;
        end
      end else if (cmd_wr) begin
        busy     <= 1'b1;
        err      <= 1'b0;
        err_code <= '0;
        cmd_word <= wdata;
        cmd_id   <= wdata[CMD_ID_LSB +: CMD_ID_W];
        ioc_q    <= wdata[CMD_IOC_BIT];
        doorbell <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hmb_host_rd.sv
module hmb_host_rd (
  input  logic        clk,
  input  logic        rst,
  input  logic        stat_rd,
  input  logic        rbuf_rd,
  input  logic [31:0] status,
  input  logic [31:0] rbuf_q,
  output logic [31:0] rdata
);
  import hmb_pkg::*;

  rsel_e       sel_q;
  logic [31:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RSEL_ZERO;
      stat_q <= '0;
    end else begin
      stat_q <= status;
      if (stat_rd)      sel_q <= RSEL_STATUS;
      else if (rbuf_rd) sel_q <= RSEL_RBUF;
      else              sel_q <= RSEL_ZERO;
    end
  end

  always_comb begin
    case (sel_q)
      RSEL_STATUS: rdata = stat_q;
      RSEL_RBUF:   rdata = rbuf_q;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/hostmbox_top.sv
module hostmbox_top #(
  parameter int         ADDR_W    = 8,
  parameter int         BUF_BYTES = 16,
  parameter logic [7:0] INIT_ID   = 8'hA5,
  localparam int        BUF_WORDS = BUF_BYTES / 4,
  localparam int        IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              r_doorbell,
  output logic [31:0]       r_cmd_word,
  input  logic [IDX_W-1:0]  r_wbuf_idx,
  output logic [31:0]       r_wbuf_data,
  input  logic              r_rbuf_we,
  input  logic [IDX_W-1:0]  r_rbuf_idx,
  input  logic [31:0]       r_rbuf_wdata,
  input  logic              r_done,
  input  logic              r_err,
  input  logic [7:0]        r_err_code
);
  import hmb_pkg::*;

  logic                cmd_wr, wbuf_wr, stat_rd, rbuf_rd;
  logic [IDX_W-1:0]    host_idx;
  logic                busy, err;
  logic [7:0]          err_code;
  logic [CMD_ID_W-1:0] cmd_id;
  logic [31:0]         rbuf_q;
  status_t             status;

  hmb_decode #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_dec (
    .addr(h_addr), .wr(h_wr_en), .rd(h_rd_en),
    .cmd_wr(cmd_wr), .wbuf_wr(wbuf_wr), .stat_rd(stat_rd), .rbuf_rd(rbuf_rd),
    .idx(host_idx)
  );

  hmb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .wdata(h_wdata),
    .done(r_done), .done_err(r_err), .done_code(r_err_code),
    .busy(busy), .err(err), .err_code(err_code), .cmd_id(cmd_id),
    .cmd_word(r_cmd_word), .doorbell(r_doorbell), .irq(h_irq)
  );

  // host -> service processor argument buffer
  hmb_sdp_ram #(.WORDS(BUF_WORDS), .DATA_W(32)) u_wbuf (
    .clk(clk), .we(wbuf_wr), .waddr(host_idx), .wdata(h_wdata),
    .raddr(r_wbuf_idx), .rdata(r_wbuf_data)
  );

  // service processor -> host result buffer
  hmb_sdp_ram #(.WORDS(BUF_WORDS), .DATA_W(32)) u_rbuf (
    .clk(clk), .we(r_rbuf_we), .waddr(r_rbuf_idx), .wdata(r_rbuf_wdata),
    .raddr(host_idx), .rdata(rbuf_q)
  );

  always_comb begin
    status          = '0;
    status.busy     = busy;
    status.err      = err;
    status.cmd_id   = cmd_id;
    status.init_id  = INIT_ID;
    status.err_code = err_code;
  end

  hmb_host_rd u_rd (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .rbuf_rd(rbuf_rd),
    .status(status), .rbuf_q(rbuf_q), .rdata(h_rdata)
  );

endmodule

// File: rtl/hmb_checker.sv
module hmb_checker (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic        busy,
  input logic        err,
  input logic        r_done,
  input logic        r_doorbell,
  input logic        h_irq,
  input logic [31:0] r_cmd_word
);

  assert_doorbell_on_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy) |=> (r_doorbell && busy));

  assert_doorbell_single_R1: assert property (@(posedge clk) disable iff (rst)
    r_doorbell |=> !r_doorbell);

  assert_no_doorbell_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> !r_doorbell);

  assert_cmd_hold_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(r_cmd_word));

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && r_done) |=> !busy);

  assert_idle_done_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && r_done && !cmd_wr) |=> (!busy && $stable(err)));

  assert_irq_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    h_irq |-> $past(busy && r_done));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    h_irq |=> !h_irq);

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({r_doorbell, h_irq}));

endmodule

bind hostmbox_top hmb_checker u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .busy(busy), .err(err),
  .r_done(r_done), .r_doorbell(r_doorbell), .h_irq(h_irq),
  .r_cmd_word(r_cmd_word)
);

// File: tb/test_hostmbox_top.sv
`timescale 1ns/1ps
module test_hostmbox_top;
  localparam int         ADDR_W  = 8;
  localparam logic [7:0] INIT_ID = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr_en = 0, h_rd_en = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        h_irq, r_doorbell;
  logic [31:0] r_cmd_word, r_wbuf_data;
  logic [1:0]  r_wbuf_idx = 0, r_rbuf_idx = 0;
  logic        r_rbuf_we = 0;
  logic [31:0] r_rbuf_wdata = 0;
  logic        r_done = 0, r_err = 0;
  logic [7:0]  r_err_code = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] rb_model [4];
  logic        m_err;
  logic [7:0]  m_code;
  logic [3:0]  m_id;

  always #10 clk = ~clk;

  hostmbox_top #(.ADDR_W(ADDR_W), .BUF_BYTES(16), .INIT_ID(INIT_ID)) i_hostmbox_top (
    .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .r_doorbell(r_doorbell),
    .r_cmd_word(r_cmd_word), .r_wbuf_idx(r_wbuf_idx), .r_wbuf_data(r_wbuf_data),
    .r_rbuf_we(r_rbuf_we), .r_rbuf_idx(r_rbuf_idx), .r_rbuf_wdata(r_rbuf_wdata),
    .r_done(r_done), .r_err(r_err), .r_err_code(r_err_code)
  );

  function automatic logic [31:0] exp_stat(logic b, logic e, logic [7:0] c, logic [3:0] id);
    return {8'h00, c, INIT_ID, id, 2'b00, e, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); h_wr_en = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr_en = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); h_rd_en = 1; h_addr = a;
    @(negedge clk); h_rd_en = 0; d = h_rdata;
  endtask

  task automatic rsp_done(logic e, logic [7:0] c);
    @(negedge clk); r_done = 1; r_err = e; r_err_code = c;
    @(negedge clk); r_done = 0;
  endtask

  initial begin
    logic [31:0] rd, w, w2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check("R11 doorbell", {31'b0, r_doorbell}, 0);
    check("R11 irq", {31'b0, h_irq}, 0);
    check("R11 rdata idle", h_rdata, 0);
    hread(8'h04, rd);
    check("R11 status", rd, exp_stat(0, 0, 8'h00, 4'h0));

    // command sweep over every id and both interrupt settings
    for (int id = 0; id < 16; id++) begin
      for (int ioc = 0; ioc < 2; ioc++) begin
        logic       e;
        logic [7:0] c;
        e = id[0] ^ ioc[0];
        c = 8'(id * 17 + ioc + 1);
        w = {8'h5C, 8'(4 * id + 4), 4'(id), 3'b000, ioc[0], 8'(8'hE0 + id)};
        hwrite(8'h00, w);
        check("R1 doorbell", {31'b0, r_doorbell}, 1);
        check("R1 cmd word", r_cmd_word, w);
        hwrite(8'h00, ~w);
        check("R1/R2 doorbell single and busy gate", {31'b0, r_doorbell}, 0);
        check("R2 cmd word kept", r_cmd_word, w);
        hread(8'h04, rd);
        check("R3 busy status", rd, exp_stat(1, 0, 8'h00, 4'(id)));
        rsp_done(e, c);
        check("R5 irq", {31'b0, h_irq}, {31'b0, ioc[0]});
        @(negedge clk);
        check("R5 irq single cycle", {31'b0, h_irq}, 0);
        hread(8'h04, rd);
        check("R4 done status", rd, exp_stat(0, e, c, 4'(id)));
        m_err = e; m_code = c; m_id = 4'(id);
      end
    end

    // done while idle is ignored
    rsp_done(1'b1, 8'h77);
    check("R4 idle done irq", {31'b0, h_irq}, 0);
    hread(8'h04, rd);
    check("R4 idle done status", rd, exp_stat(0, m_err, m_code, m_id));

    // write buffer: host writes, service processor reads
    for (int i = 0; i < 4; i++) hwrite(8'(8'h80 + 4 * i), 32'hA000_0000 + 32'(i * 32'h0101_0101));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); r_wbuf_idx = 2'(i);
      @(negedge clk);
      check("R6 wbuf word", r_wbuf_data, 32'hA000_0000 + 32'(i * 32'h0101_0101));
      hread(8'(8'h80 + 4 * i), rd);
      check("R8 wbuf reads zero", rd, 0);
    end

    // read buffer: service processor writes, host reads
    for (int i = 0; i < 4; i++) begin
      rb_model[i] = 32'h3C00_0000 ^ 32'(i * 32'h0011_0203 + 7);
      @(negedge clk); r_rbuf_we = 1; r_rbuf_idx = 2'(i); r_rbuf_wdata = rb_model[i];
      @(negedge clk); r_rbuf_we = 0;
    end
    for (int i = 0; i < 4; i++) begin
      hread(8'(8'h90 + 4 * i), rd);
      check("R7 rbuf word", rd, rb_model[i]);
      hwrite(8'(8'h90 + 4 * i), 32'hDEAD_0000 + 32'(i));
      hread(8'(8'h90 + 4 * i), rd);
      check("R9 rbuf write dropped", rd, rb_model[i]);
    end
    hwrite(8'h04, 32'hFFFF_FFFF);
    hread(8'h04, rd);
    check("R9 status write dropped", rd, exp_stat(0, m_err, m_code, m_id));

    // unmapped writes then full window read sweep
    for (int k = 40; k < 64; k += 5) hwrite(8'(4 * k), 32'h1234_5678);
    check("R9 unmapped write no doorbell", {31'b0, r_doorbell}, 0);
    for (int k = 0; k < 64; k++) begin
      logic [31:0] ex;
      if (k == 1) ex = exp_stat(0, m_err, m_code, m_id);
      else if (k >= 36 && k < 40) ex = rb_model[k - 36];
      else ex = 0;
      hread(8'(4 * k), rd);
      check("R8 window sweep", rd, ex);
    end

    // done and command write in the same cycle
    w  = 32'h0000_9100 | 32'h0000_0042;
    w2 = 32'h0000_4033;
    hwrite(8'h00, w);
    check("R10 setup doorbell", {31'b0, r_doorbell}, 1);
    @(negedge clk);
    r_done = 1; r_err = 0; r_err_code = 8'h3C;
    h_wr_en = 1; h_addr = 8'h00; h_wdata = w2;
    @(negedge clk);
    r_done = 0; h_wr_en = 0;
    check("R10 no doorbell", {31'b0, r_doorbell}, 0);
    check("R10 irq taken", {31'b0, h_irq}, 1);
    check("R10 cmd word kept", r_cmd_word, w);
    hread(8'h04, rd);
    check("R10 status", rd, exp_stat(0, 0, 8'h3C, 4'h9));
    hwrite(8'h00, w2);
    check("R10 next command accepted", {31'b0, r_doorbell}, 1);
    check("R10 next cmd word", r_cmd_word, w2);
    hread(8'h04, rd);
    check("R3 err cleared on accept", rd, exp_stat(1, 0, 8'h00, 4'h4));
    rsp_done(1'b0, 8'h00);
    check("R5 no irq when bit 8 clear", {31'b0, h_irq}, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule